// File: doc/BRIEF.md
# Pipelined Signed Multiply-Accumulate Unit

This unit forms the signed product of two operands and folds it into a wide two's-complement accumulator. Each product is either added to the running total (with a one-bit carry added on top) or subtracted from it (the carry is subtracted along with the product). A load strobe starts a new total from an external seed value plus the current product. This is how a new dot product or filter tap sum begins without losing a cycle.

One parameter sets the latency, from one to four clock-enable cycles. It decides how many register stages sit on the operand inputs and whether a register follows the multiplier. The accumulator register is always the last stage. The control strobes and the seed travel through the same stages as the operands, so every control value acts on the product it was sampled with. The accumulator and the seed are as wide as the two operands together. The total wraps on overflow. There is no rounding, no saturation and no overflow flag.

Top module: `smac_pipe`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every pipeline register and the accumulator become zero, whatever the state of `ce_i`, so `acc_o` reads 0 after that edge.
- R2: With `add_i` = 1 and `load_i` = 0, a sample updates the accumulator to acc + A*B + `cin_i`, where A and B are taken as signed two's-complement numbers.
- R3: With `add_i` = 0 and `load_i` = 0, a sample updates the accumulator to acc − (A*B + `cin_i`).
- R4: With `load_i` = 1, a sample replaces the accumulator with A*B + `preload_i`, and `add_i` and `cin_i` have no effect on that update. Loads on consecutive samples each restart the total.
- R5: While `ce_i` is low (and `rst_n` high), no register changes, so `acc_o` holds its value and input changes are ignored.
- R6: The inputs sampled at an enabled edge reach `acc_o` after LATENCY enabled edges, counting that edge. LATENCY 1 has no operand register and no product register. LATENCY 2 has one operand stage. LATENCY 3 has one operand stage and a product register. LATENCY 4 has two operand stages and a product register.
- R7: `load_i`, `add_i`, `cin_i` and `preload_i` are delayed together with their operands, so each one acts on the product sampled in the same cycle, even when `ce_i` stalls the pipeline between samples.
- R8: Accumulation wraps modulo 2^(A_W+B_W) with no saturation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ce_i | input | 1 | Clock enable for all registers, active high |
| a_i | input | A_W | Signed multiplicand |
| b_i | input | B_W | Signed multiplier |
| add_i | input | 1 | 1 adds the product, 0 subtracts it |
| cin_i | input | 1 | Carry applied together with the product |
| load_i | input | 1 | Restart the total from seed plus product |
| preload_i | input | A_W+B_W | Seed value used by a load |
| acc_o | output | A_W+B_W | Accumulator value |

## Verification
The hardest case to reach is a stalled pipeline that holds several different control values at once. Operands, load and add/subtract settings then sit in different stages while `ce_i` is low. Misrouting any one of them shows up only after the pipeline resumes, and at a different cycle for each latency. The stimulus drives all four latency variants side by side. It runs bursts of random enable patterns with frequent loads and mode flips. A reference model delays each sampled bundle by the right number of enabled edges per variant and compares every cycle. Directed runs add a single-sample impulse, back-to-back loads, full-scale products that force a wrap, and a reset asserted while the enable is low.

// File: rtl/smac_pkg.sv
// Package: shared types and latency-to-structure mapping for the multiply-accumulate unit.
// Assumes the latency parameter is in the range 1..4.
package smac_pkg;

    // Control strobes that travel with each operand pair.
    typedef struct packed {
        logic load;
        logic add;
        logic cin;
    } smac_ctrl_t;

    localparam int unsigned SMAC_CTRL_W = 3;

    // Number of register stages placed on the operand inputs.
    function automatic int unsigned smac_in_stages(input int unsigned lat);
        return (lat >= 4) ? 2 : ((lat >= 2) ? 1 : 0);
    endfunction

    // Number of register stages placed right after the multiplier.
    function automatic int unsigned smac_prod_stages(input int unsigned lat);
        return (lat >= 3) ? 1 : 0;
    endfunction

endpackage

// File: rtl/smac_delay.sv
// Module: smac_delay
// A clock-enabled shift line DEPTH registers long for a W-bit bundle.
// Assumes DEPTH >= 1. Synchronous active-low reset clears every stage to zero.
module smac_delay #(
    parameter int unsigned W     = 8,
    parameter int unsigned DEPTH = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ce_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] stg_q [DEPTH];

    // Shift the bundle one stage per enabled edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(DEPTH); i++) begin
                stg_q[i] <= '0;
            end
        end else if (ce_i) begin
            stg_q[0] <= d_i;
            for (int i = 1; i < int'(DEPTH); i++) begin
                stg_q[i] <= stg_q[i-1];
            end
        end
    end

    assign q_o = stg_q[DEPTH-1];

    // R5: a stalled line keeps its output.
    p_line_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !ce_i |=> $stable(q_o));

endmodule

// File: rtl/smac_mult.sv
// Module: smac_mult
// Combinational signed multiplier that gives the full-width A_W+B_W product.
// Assumes both operands are two's-complement numbers.
module smac_mult #(
    parameter int unsigned A_W = 25,
    parameter int unsigned B_W = 18,
    localparam int unsigned P_W = A_W + B_W
) (
    input  logic [A_W-1:0] a_i,
    input  logic [B_W-1:0] b_i,
    output logic [P_W-1:0] prod_o
);

    logic signed [P_W-1:0] a_ext;
    logic signed [P_W-1:0] b_ext;

    // Sign-extend both operands to the product width, then multiply.
    always_comb begin
        a_ext  = $signed({{B_W{a_i[A_W-1]}}, a_i});
        b_ext  = $signed({{A_W{b_i[B_W-1]}}, b_i});
        prod_o = a_ext * b_ext;
    end

endmodule

// File: rtl/smac_accum.sv
// Module: smac_accum
// Accumulator register: adds, subtracts or loads the incoming product.
// Assumes the product, controls and seed arriving here are already aligned.
// The total wraps modulo 2^P_W.
module smac_accum
    import smac_pkg::*;
#(
    parameter int unsigned P_W = 43
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ce_i,
    input  logic [P_W-1:0] prod_i,
    input  smac_ctrl_t     ctrl_i,
    input  logic [P_W-1:0] pre_i,
    output logic [P_W-1:0] acc_o
);

    logic [P_W-1:0] acc_q;
    logic [P_W-1:0] addend;
    logic [P_W-1:0] acc_nxt;

    // Pick the next total from load, add or subtract.
    always_comb begin
        addend = prod_i + {{(P_W-1){1'b0}}, ctrl_i.cin};
        if (ctrl_i.load) begin
            acc_nxt = prod_i + pre_i;
        end else if (ctrl_i.add) begin
            acc_nxt = acc_q + addend;
        end else begin
            acc_nxt = acc_q - addend;
        end
    end

    // Accumulator register with synchronous reset and clock enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (ce_i) begin
            acc_q <= acc_nxt;
        end
    end

    assign acc_o = acc_q;

    // R4: a load takes product plus seed.
    p_load_seed_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ce_i && ctrl_i.load |=> acc_o == $past(prod_i) + $past(pre_i));

    // R2: add mode grows the total by product and carry.
    p_add_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ce_i && !ctrl_i.load && ctrl_i.add |=>
        acc_o == $past(acc_o) + $past(prod_i) + {{(P_W-1){1'b0}}, $past(ctrl_i.cin)});

    // R3: subtract mode takes product and carry away.
    p_sub_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ce_i && !ctrl_i.load && !ctrl_i.add |=>
        acc_o == $past(acc_o) - $past(prod_i) - {{(P_W-1){1'b0}}, $past(ctrl_i.cin)});

endmodule

// File: rtl/smac_pipe.sv
// Module: smac_pipe (top)
// Pipelined signed multiply-accumulate unit.
// LATENCY (1..4) places 0, 1 or 2 operand stages and an optional product stage.
// The accumulator is always the last stage. Controls and seed travel with their
// operands. Assumes A_W in 1..25, B_W in 1..18, A_W+B_W >= 2.
module smac_pipe
    import smac_pkg::*;
#(
    parameter int unsigned A_W     = 25,
    parameter int unsigned B_W     = 18,
    parameter int unsigned LATENCY = 3,
    localparam int unsigned P_W    = A_W + B_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ce_i,
    input  logic [A_W-1:0] a_i,
    input  logic [B_W-1:0] b_i,
    input  logic           add_i,
    input  logic           cin_i,
    input  logic           load_i,
    input  logic [P_W-1:0] preload_i,
    output logic [P_W-1:0] acc_o
);

    localparam int unsigned IN_ST = smac_in_stages(LATENCY);
    localparam int unsigned PR_ST = smac_prod_stages(LATENCY);
    localparam int unsigned OPV_W = A_W + B_W + SMAC_CTRL_W + P_W;
    localparam int unsigned PRV_W = P_W + SMAC_CTRL_W + P_W;

    smac_ctrl_t       ctrl_in;
    logic [OPV_W-1:0] opv_in;
    logic [OPV_W-1:0] opv_st;
    logic [A_W-1:0]   a_st;
    logic [B_W-1:0]   b_st;
    smac_ctrl_t       ctrl_st;
    logic [P_W-1:0]   pre_st;
    logic [P_W-1:0]   prod_raw;
    logic [PRV_W-1:0] prv_in;
    logic [PRV_W-1:0] prv_st;
    logic [P_W-1:0]   prod_al;
    smac_ctrl_t       ctrl_al;
    logic [P_W-1:0]   pre_al;

    // Bundle operands, controls and seed so they move as one.
    always_comb begin
        ctrl_in.load = load_i;
        ctrl_in.add  = add_i;
        ctrl_in.cin  = cin_i;
        opv_in       = {a_i, b_i, ctrl_in, preload_i};
    end

    // Operand stages: none, one or two, chosen by LATENCY.
    generate
        if (IN_ST > 0) begin : g_in_reg
            smac_delay #(.W(OPV_W), .DEPTH(IN_ST)) u_in_dly (
                .clk   (clk),
                .rst_n (rst_n),
                .ce_i  (ce_i),
                .d_i   (opv_in),
                .q_o   (opv_st)
            );
        end else begin : g_in_thru
            assign opv_st = opv_in;
        end
    endgenerate

    // Unpack the staged operand bundle.
    assign {a_st, b_st, ctrl_st, pre_st} = opv_st;

    smac_mult #(.A_W(A_W), .B_W(B_W)) u_mult (
        .a_i    (a_st),
        .b_i    (b_st),
        .prod_o (prod_raw)
    );

    // Carry controls and seed alongside the product.
    assign prv_in = {prod_raw, ctrl_st, pre_st};

    // Optional product stage, present for LATENCY 3 and 4.
    generate
        if (PR_ST > 0) begin : g_prod_reg
            smac_delay #(.W(PRV_W), .DEPTH(PR_ST)) u_prod_dly (
                .clk   (clk),
                .rst_n (rst_n),
                .ce_i  (ce_i),
                .d_i   (prv_in),
                .q_o   (prv_st)
            );
        end else begin : g_prod_thru
            assign prv_st = prv_in;
        end
    endgenerate

    // Unpack the aligned product bundle.
    assign {prod_al, ctrl_al, pre_al} = prv_st;

    smac_accum #(.P_W(P_W)) u_acc (
        .clk    (clk),
        .rst_n  (rst_n),
        .ce_i   (ce_i),
        .prod_i (prod_al),
        .ctrl_i (ctrl_al),
        .pre_i  (pre_al),
        .acc_o  (acc_o)
    );

    // R1: reset clears the output whatever the enable.
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> acc_o == '0);

    // R5: no output change while the enable is low.
    p_stall_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !ce_i |=> $stable(acc_o));

endmodule

// File: tb/smac_pipe_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: drives all four latency variants with the same stimulus.
// A per-cycle reference model queues the expected outputs, and a monitor
// compares them against the design.
module smac_pipe_tb_top;

    localparam int unsigned A_W = 25;
    localparam int unsigned B_W = 18;
    localparam int unsigned P_W = A_W + B_W;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           ce = 1'b0;
    logic [A_W-1:0] a = '0;
    logic [B_W-1:0] b = '0;
    logic           add = 1'b0;
    logic           cin = 1'b0;
    logic           load = 1'b0;
    logic [P_W-1:0] pre = '0;
    logic [P_W-1:0] acc_w [4];

    always #10 clk = ~clk;

    for (genvar k = 0; k < 4; k++) begin : g_lat
        smac_pipe #(.A_W(A_W), .B_W(B_W), .LATENCY(k + 1)) dut_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .ce_i      (ce),
            .a_i       (a),
            .b_i       (b),
            .add_i     (add),
            .cin_i     (cin),
            .load_i    (load),
            .preload_i (pre),
            .acc_o     (acc_w[k])
        );
    end

    // Reference model state: history of enabled samples, newest at index 0.
    logic [P_W-1:0]   h_prod [4];
    logic             h_load [4];
    logic             h_add  [4];
    logic             h_cin  [4];
    logic [P_W-1:0]   h_pre  [4];
    logic [P_W-1:0]   m_acc  [4];

    logic [4*P_W-1:0] exp_q [$];
    string            tag_q [$];
    int               n_vec  = 0;
    int               n_fail = 0;
    bit               done   = 1'b0;

    initial begin
        for (int k = 0; k < 4; k++) begin
            h_prod[k] = '0; h_load[k] = 1'b0; h_add[k] = 1'b0;
            h_cin[k] = 1'b0; h_pre[k] = '0; m_acc[k] = '0;
        end
    end

    // Driver: applies one cycle of stimulus and queues the expected outputs.
    task automatic drive(input logic rs, input logic en, input logic ld, input logic ad,
                         input logic ci, input logic [A_W-1:0] av, input logic [B_W-1:0] bv,
                         input logic [P_W-1:0] pv, input string tag);
        logic signed [A_W-1:0] sa;
        logic signed [B_W-1:0] sb;
        longint                pl;
        logic [P_W-1:0]        pr;
        @(negedge clk);
        rst_n = rs; ce = en; load = ld; add = ad; cin = ci; a = av; b = bv; pre = pv;
        sa = av; sb = bv;
        pl = longint'(sa) * longint'(sb);
        pr = pl[P_W-1:0];
        if (!rs) begin
            for (int k = 0; k < 4; k++) begin
                h_prod[k] = '0; h_load[k] = 1'b0; h_add[k] = 1'b0;
                h_cin[k] = 1'b0; h_pre[k] = '0; m_acc[k] = '0;
            end
        end else if (en) begin
            for (int k = 3; k > 0; k--) begin
                h_prod[k] = h_prod[k-1]; h_load[k] = h_load[k-1]; h_add[k] = h_add[k-1];
                h_cin[k] = h_cin[k-1]; h_pre[k] = h_pre[k-1];
            end
            h_prod[0] = pr; h_load[0] = ld; h_add[0] = ad; h_cin[0] = ci; h_pre[0] = pv;
            for (int k = 0; k < 4; k++) begin
                if (h_load[k])
                    m_acc[k] = h_prod[k] + h_pre[k];
                else if (h_add[k])
                    m_acc[k] = m_acc[k] + h_prod[k] + {{(P_W-1){1'b0}}, h_cin[k]};
                else
                    m_acc[k] = m_acc[k] - h_prod[k] - {{(P_W-1){1'b0}}, h_cin[k]};
            end
        end
        exp_q.push_back({m_acc[3], m_acc[2], m_acc[1], m_acc[0]});
        tag_q.push_back(tag);
    endtask

    // Monitor: pops one expected item per cycle and compares all variants.
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (exp_q.size() > 0) begin
                logic [4*P_W-1:0] ev;
                string            tg;
                ev = exp_q.pop_front();
                tg = tag_q.pop_front();
                for (int k = 0; k < 4; k++) begin
                    n_vec++;
                    if (acc_w[k] !== ev[k*P_W +: P_W]) begin
                        n_fail++;
                        $display("FAIL %s latency %0d: acc_o actual %h expected %h",
                                 tg, k + 1, acc_w[k], ev[k*P_W +: P_W]);
                    end
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    localparam logic [A_W-1:0] A_MIN = {1'b1, {(A_W-1){1'b0}}};
    localparam logic [B_W-1:0] B_MIN = {1'b1, {(B_W-1){1'b0}}};

    initial begin
        // R1: reset state.
        repeat (3) drive(0, 0, 0, 0, 0, '0, '0, '0, "R1 reset");
        // R2: add mode, mixed signs and carry.
        drive(1, 1, 0, 1, 0, 25'd3, 18'd5, '0, "R2 add");
        drive(1, 1, 0, 1, 1, -25'sd7, 18'd9, '0, "R2 add");
        drive(1, 1, 0, 1, 1, -25'sd100, -18'sd3, '0, "R2 add");
        drive(1, 1, 0, 1, 0, 25'd12345, -18'sd77, '0, "R2 add");
        repeat (4) drive(1, 1, 0, 1, 0, '0, '0, '0, "R2 add flush");
        // R3: subtract mode.
        drive(1, 1, 0, 0, 1, 25'd40, 18'd2, '0, "R3 sub");
        drive(1, 1, 0, 0, 0, -25'sd6, 18'd11, '0, "R3 sub");
        drive(1, 1, 0, 0, 1, 25'd999, -18'sd1000, '0, "R3 sub");
        repeat (4) drive(1, 1, 0, 0, 0, '0, '0, '0, "R3 sub flush");
        // R4: loads, back to back, with add and carry set during them.
        drive(1, 1, 1, 1, 1, 25'd2, 18'd3, 43'd1000, "R4 load");
        drive(1, 1, 1, 0, 1, -25'sd4, 18'd8, 43'h7FF_0000_0000, "R4 load");
        drive(1, 1, 1, 1, 0, 25'd10, 18'd10, 43'd5, "R4 load");
        drive(1, 1, 0, 1, 1, 25'd1, 18'd1, '0, "R4 after load");
        repeat (4) drive(1, 1, 0, 1, 0, '0, '0, '0, "R4 flush");
        // R5: enable low with changing inputs in the middle of a stream.
        drive(1, 1, 0, 1, 0, 25'd50, 18'd2, '0, "R5 stall");
        repeat (5) drive(1, 0, $urandom_range(0, 1), $urandom_range(0, 1), 1,
                         A_W'($urandom), B_W'($urandom), P_W'($urandom), "R5 stall ignored");
        repeat (4) drive(1, 1, 0, 1, 0, '0, '0, '0, "R5 resume");
        // R6: single impulse after reset exposes each latency.
        drive(0, 1, 0, 0, 0, '0, '0, '0, "R6 reset");
        drive(1, 1, 0, 1, 0, 25'd3, 18'd5, '0, "R6 impulse");
        repeat (5) drive(1, 1, 0, 1, 0, '0, '0, '0, "R6 impulse");
        // R8: full-scale products force a wrap.
        drive(1, 1, 1, 1, 0, A_MIN, B_MIN, '0, "R8 wrap");
        repeat (3) drive(1, 1, 0, 1, 1, A_MIN, B_MIN, '0, "R8 wrap");
        drive(1, 1, 0, 0, 1, A_MIN, B_MIN, '0, "R8 wrap");
        repeat (4) drive(1, 1, 0, 1, 0, '0, '0, '0, "R8 flush");
        // R7: random controls with random stalls.
        for (int i = 0; i < 400; i++) begin
            drive(1, ($urandom_range(0, 3) != 0), ($urandom_range(0, 5) == 0),
                  $urandom_range(0, 1), $urandom_range(0, 1),
                  A_W'($urandom), B_W'($urandom), {$urandom, $urandom}, "R7 aligned");
        end
        // R1: reset while the enable is low still clears.
        drive(0, 0, 1, 1, 1, 25'd7, 18'd7, 43'd7, "R1 reset over stall");
        repeat (3) drive(1, 0, 0, 1, 0, '0, '0, '0, "R1 after reset");
        repeat (3) @(posedge clk);
        #6;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule